// File: doc/BRIEF.md
# DRAM Refresh and Initialization Sequencer

This block keeps an asynchronous page-mode DRAM refreshed and brings it up after reset. Once reset is released it holds every strobe inactive for a programmable power-up wait. It then runs a fixed number of warm-up refresh cycles without asking anyone, and only after the last of these does it raise its ready flag. From then on an interval timer produces refresh tokens. These wait in a small saturating backlog, and while one is outstanding the block asks the access arbiter for the memory. Each grant runs exactly one refresh.

A refresh takes one of two shapes, chosen by a mode input sampled when the refresh starts. In the strobe-first style both column strobes fall ahead of the row strobe and the device picks the row itself. In the row-address style the block drives a row from its own wrapping counter while the column strobes stay high. All delays are parameters counted in clock cycles. Data transfer is outside this block.

Top module: `dram_refresh_seq`

## Requirements
- R1: For the first PWRUP_CYC cycles after reset the row strobe and both column strobes are high (inactive), and ready and the request are low.
- R2: Right after the power-up wait, INIT_REFRESHES refresh cycles run back to back without a grant. The ready flag rises in the cycle after the last precharge ends and never falls again.
- R3: In strobe-first mode both column strobes are low for T_CSR cycles before the row strobe falls. They stay low for the first T_CHR cycles of the row-strobe low time and return high before the row strobe rises.
- R4: The row strobe stays low for exactly T_RAS cycles per refresh. It is followed by at least T_RP high cycles before either strobe falls again.
- R5: In row-address mode both column strobes stay high for the whole refresh, and the row address stays stable while the row strobe is low.
- R6: The row counter starts at 0 after reset and advances by one after each row-address refresh, wrapping from 2^ROW_W-1 to 0. Strobe-first refreshes leave it unchanged.
- R7: Once ready, one refresh token is added every REF_INTERVAL cycles. The first request appears exactly REF_INTERVAL cycles after ready rises.
- R8: The request is high exactly when the block is ready, idle, and holds at least one token. A grant sampled with the request high starts a refresh in the next cycle and consumes one token.
- R9: The backlog holds at most PEND_MAX tokens, and tokens arriving while it is full are dropped.
- R10: The refresh style follows the mode input (1 = strobe-first, 0 = row-address) as sampled in the cycle a refresh is launched.
- R11: The two column strobes are always driven to the same level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| use_cbr_i | input | 1 | Refresh style for the next launch: 1 strobe-first, 0 row-address |
| grant_i | input | 1 | Arbiter grant for a pending refresh |
| req_o | output | 1 | Refresh request to the arbiter |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_lo_n_o | output | 1 | Lower-byte column strobe, active low |
| cas_hi_n_o | output | 1 | Upper-byte column strobe, active low |
| row_addr_o | output | ROW_W | Row address for row-address refreshes |
| ready_o | output | 1 | Memory initialized and usable |

## Verification
A wrong phase counter shows within one refresh as a row-strobe low time that is too short or too long, or as a column strobe that moves while the row strobe is low. A corrupted warm-up count moves the ready edge, so the error is visible the cycle ready rises. Backlog errors are slower to show. A lost or extra token appears only as a request that rises or stays up one interval off the expected cycle. The row counter is observed at every row-address refresh, and a wrap fault is visible only after a full sweep of 2^ROW_W rows.

// File: rtl/dram_ref_pkg.sv
package dram_ref_pkg;
    typedef enum logic [2:0] {
        ST_PWRUP  = 3'd0,
        ST_CSETUP = 3'd1,
        ST_RASLO  = 3'd2,
        ST_PRECH  = 3'd3,
        ST_IDLE   = 3'd4
    } ref_st_e;
endpackage

// File: rtl/dram_ref_tick.sv
module dram_ref_tick #(
    parameter int INTERVAL = 1560
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    output logic tick_o
);
    localparam int TW = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;

    logic [TW-1:0] tmr_d, tmr_q;
    logic          wrap;

    always_comb begin
        wrap  = (tmr_q == TW'(INTERVAL - 1));
        tmr_d = tmr_q;
        if (en_i) begin
            tmr_d = wrap ? '0 : tmr_q + 1'b1;
        end
        tick_o = en_i && wrap;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end
endmodule

// File: rtl/dram_ref_pend.sv
module dram_ref_pend #(
    parameter int PEND_MAX = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic take_i,
    output logic nonzero_o
);
    localparam int PW = $clog2(PEND_MAX + 1);

    logic [PW-1:0] cnt_d, cnt_q;
    logic [PW-1:0] after_take;

    always_comb begin
        after_take = take_i ? cnt_q - 1'b1 : cnt_q;
        cnt_d      = after_take;
        if (tick_i && (after_take < PW'(PEND_MAX))) begin
            cnt_d = after_take + 1'b1;
        end
        nonzero_o = (cnt_q != '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/dram_ref_row.sv
module dram_ref_row #(
    parameter int ROW_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv_i,
    output logic [ROW_W-1:0] row_o
);
    logic [ROW_W-1:0] row_d, row_q;

    always_comb begin
        row_d = adv_i ? row_q + 1'b1 : row_q;
        row_o = row_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) row_q <= '0;
        else        row_q <= row_d;
    end
endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq #(
    parameter int PWRUP_CYC      = 20000,
    parameter int INIT_REFRESHES = 8,
    parameter int REF_INTERVAL   = 1560,
    parameter int T_CSR          = 1,
    parameter int T_CHR          = 1,
    parameter int T_RAS          = 6,
    parameter int T_RP           = 5,
    parameter int PEND_MAX       = 8,
    parameter int ROW_W          = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             use_cbr_i,
    input  logic             grant_i,
    output logic             req_o,
    output logic             ras_n_o,
    output logic             cas_lo_n_o,
    output logic             cas_hi_n_o,
    output logic [ROW_W-1:0] row_addr_o,
    output logic             ready_o
);
    import dram_ref_pkg::*;

    localparam int M1     = (PWRUP_CYC > T_RAS) ? PWRUP_CYC : T_RAS;
    localparam int M2     = (M1 > T_RP) ? M1 : T_RP;
    localparam int M3     = (M2 > T_CSR) ? M2 : T_CSR;
    localparam int CNT_W  = $clog2(M3 + 1);
    localparam int INIT_W = $clog2(INIT_REFRESHES + 1);

    typedef struct packed {
        ref_st_e           st;
        logic [CNT_W-1:0]  cnt;
        logic              cbr;
        logic [INIT_W-1:0] init_left;
        logic              rdy;
    } seq_t;

    seq_t q, d;
    logic tick, pend_nz, take, adv, launch, cas_on;

    dram_ref_tick #(.INTERVAL(REF_INTERVAL)) u_tick (
        .clk(clk), .rst_n(rst_n), .en_i(q.rdy), .tick_o(tick)
    );

    dram_ref_pend #(.PEND_MAX(PEND_MAX)) u_pend (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .take_i(take),
        .nonzero_o(pend_nz)
    );

    dram_ref_row #(.ROW_W(ROW_W)) u_row (
        .clk(clk), .rst_n(rst_n), .adv_i(adv), .row_o(row_addr_o)
    );

    always_comb begin
        d      = q;
        take   = 1'b0;
        adv    = 1'b0;
        launch = 1'b0;
        req_o  = q.rdy && (q.st == ST_IDLE) && pend_nz;

        unique case (q.st)
            ST_PWRUP: begin
                d.cnt = q.cnt + 1'b1;
                if (q.cnt == CNT_W'(PWRUP_CYC - 1)) launch = 1'b1;
            end
            ST_CSETUP: begin
                d.cnt = q.cnt + 1'b1;
                if (q.cnt == CNT_W'(T_CSR - 1)) begin
                    d.st  = ST_RASLO;
                    d.cnt = '0;
                end
            end
            ST_RASLO: begin
                d.cnt = q.cnt + 1'b1;
                if (q.cnt == CNT_W'(T_RAS - 1)) begin
                    d.st  = ST_PRECH;
                    d.cnt = '0;
                    adv   = !q.cbr;
                end
            end
            ST_PRECH: begin
                d.cnt = q.cnt + 1'b1;
                if (q.cnt == CNT_W'(T_RP - 1)) begin
                    if (q.init_left != '0) begin
                        launch = 1'b1;
                    end else begin
                        d.st  = ST_IDLE;
                        d.cnt = '0;
                        d.rdy = 1'b1;
                    end
                end
            end
            ST_IDLE: begin
                if (req_o && grant_i) begin
                    launch = 1'b1;
                    take   = 1'b1;
                end
            end
            default: d.st = ST_IDLE;
        endcase

        if (launch) begin
            d.cbr = use_cbr_i;
            d.st  = use_cbr_i ? ST_CSETUP : ST_RASLO;
            d.cnt = '0;
            if (!q.rdy) d.init_left = q.init_left - 1'b1;
        end

        cas_on     = (q.st == ST_CSETUP) ||
                     ((q.st == ST_RASLO) && q.cbr && (q.cnt < CNT_W'(T_CHR)));
        ras_n_o    = (q.st != ST_RASLO);
        cas_lo_n_o = !cas_on;
        cas_hi_n_o = !cas_on;
        ready_o    = q.rdy;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st        <= ST_PWRUP;
            q.cnt       <= '0;
            q.cbr       <= 1'b0;
            q.init_left <= INIT_W'(INIT_REFRESHES);
            q.rdy       <= 1'b0;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/dram_ref_seq_chk.sv
module dram_ref_seq_chk #(
    parameter int T_RAS = 6,
    parameter int T_RP  = 5,
    parameter int ROW_W = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_o,
    input logic             ras_n_o,
    input logic             cas_lo_n_o,
    input logic             cas_hi_n_o,
    input logic [ROW_W-1:0] row_addr_o,
    input logic             ready_o
);
    logic [15:0] lo_q, hi_q;
    logic        cas_seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_q       <= '0;
            hi_q       <= 16'hFFFF;
            cas_seen_q <= 1'b0;
        end else begin
            lo_q       <= ras_n_o ? '0 : lo_q + 1'b1;
            hi_q       <= !ras_n_o ? '0 : ((hi_q == 16'hFFFF) ? hi_q : hi_q + 1'b1);
            cas_seen_q <= ras_n_o ? 1'b0 : (cas_seen_q || !cas_lo_n_o);
        end
    end

    a_r11_cas_pair: assert property (@(posedge clk) disable iff (!rst_n)
        cas_lo_n_o == cas_hi_n_o);

    a_r3_cas_leads_ras: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ras_n_o) && !cas_lo_n_o) |-> !$past(cas_lo_n_o));

    a_r3_cas_fall_only_precharged: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cas_lo_n_o) |-> ras_n_o);

    a_r4_ras_width: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ras_n_o) |-> (lo_q == 16'(T_RAS)));

    a_r4_precharge: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ras_n_o) || $fell(cas_lo_n_o)) |-> (hi_q >= 16'(T_RP)));

    a_r8_req_idle: assert property (@(posedge clk) disable iff (!rst_n)
        req_o |-> (ready_o && ras_n_o && cas_lo_n_o));

    a_r2_ready_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |=> ready_o);

    a_r5_row_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!ras_n_o && $past(!ras_n_o)) |-> $stable(row_addr_o));

    a_r6_row_step: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ras_n_o) && !cas_seen_q) |->
        (row_addr_o == ROW_W'($past(row_addr_o) + 1'b1)));
endmodule

bind dram_refresh_seq dram_ref_seq_chk #(
    .T_RAS(T_RAS), .T_RP(T_RP), .ROW_W(ROW_W)
) u_seq_chk (
    .clk(clk), .rst_n(rst_n), .req_o(req_o), .ras_n_o(ras_n_o),
    .cas_lo_n_o(cas_lo_n_o), .cas_hi_n_o(cas_hi_n_o),
    .row_addr_o(row_addr_o), .ready_o(ready_o)
);

// File: tb/test_dram_refresh_seq.sv
module test_dram_refresh_seq;
    localparam int CLK_PERIOD = 10;
    localparam int PWRUP = 20, INIT = 8, RI = 12, TCSR = 2, TCHR = 2;
    localparam int TRAS = 4, TRP = 3, PMAX = 4, RW = 9;
    localparam int WD_CYC = 20000;

    logic clk = 1'b0, rst_n = 1'b0, cbr = 1'b1, grant = 1'b0;
    logic req, ras_n, cas_lo_n, cas_hi_n, ready;
    logic [RW-1:0] row;

    always #(CLK_PERIOD / 2) clk = ~clk;

    dram_refresh_seq #(
        .PWRUP_CYC(PWRUP), .INIT_REFRESHES(INIT), .REF_INTERVAL(RI),
        .T_CSR(TCSR), .T_CHR(TCHR), .T_RAS(TRAS), .T_RP(TRP),
        .PEND_MAX(PMAX), .ROW_W(RW)
    ) i_dram_refresh_seq (
        .clk(clk), .rst_n(rst_n), .use_cbr_i(cbr), .grant_i(grant),
        .req_o(req), .ras_n_o(ras_n), .cas_lo_n_o(cas_lo_n),
        .cas_hi_n_o(cas_hi_n), .row_addr_o(row), .ready_o(ready)
    );

    typedef struct packed {
        logic ras; logic cas; logic achk; logic [RW-1:0] addr;
    } slot_t;

    slot_t q[$];
    slot_t e;
    int checks = 0, fails = 0;
    int pw, init_left, ph, pend, tcnt, mrow, cyc;
    logic e_busy, e_req, e_ready;
    string tag = "R8";
    int init_falls, rdy_cyc, req_cyc, last_ror;
    logic prev_ras, wrap_ok;

    task automatic chk(input string r, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s cycle %0d: actual %0d expected %0d", r, cyc, act, exp);
        end
    endtask

    task automatic push_seq(input logic use_cbr);
        if (use_cbr) begin
            for (int i = 0; i < TCSR; i++) q.push_back('{1'b1, 1'b0, 1'b0, '0});
            for (int i = 0; i < TRAS; i++)
                q.push_back('{1'b0, (i < TCHR) ? 1'b0 : 1'b1, 1'b0, '0});
        end else begin
            for (int i = 0; i < TRAS; i++) q.push_back('{1'b0, 1'b1, 1'b1, RW'(mrow)});
            mrow = (mrow + 1) % (1 << RW);
        end
        for (int i = 0; i < TRP; i++) q.push_back('{1'b1, 1'b1, 1'b0, '0});
    endtask

    // Reference model: compares at each falling edge, then predicts next cycle
    always @(negedge clk) begin
        logic acc, tick, launch;
        if (!rst_n) begin
            q.delete();
            e = '{1'b1, 1'b1, 1'b0, '0};
            e_busy = 0; e_req = 0; e_ready = 0;
            pw = 1; init_left = INIT; ph = 0; pend = 0; tcnt = 0; mrow = 0;
            cyc = 0; init_falls = 0; rdy_cyc = -1; req_cyc = -1;
            prev_ras = 1; wrap_ok = 0; last_ror = -1;
        end else begin
            cyc++;
            chk("R4", ras_n, e.ras);
            chk("R3", cas_lo_n, e.cas);
            chk("R11", cas_hi_n, cas_lo_n);
            if (e.achk) chk("R5", row, e.addr);
            chk("R2", ready, e_ready);
            chk(tag, req, e_req);
            if (prev_ras && !ras_n) begin
                if (!ready) init_falls++;
                if (cas_lo_n) begin
                    if (last_ror == (1 << RW) - 1 && row == 0) wrap_ok = 1;
                    last_ror = row;
                end
            end
            prev_ras = ras_n;
            if (ready && rdy_cyc < 0) rdy_cyc = cyc;
            if (req && req_cyc < 0) req_cyc = cyc;
            acc = e_req && grant;
            tick = 0;
            if (e_ready) begin
                tcnt++;
                if (tcnt == RI) begin tick = 1; tcnt = 0; end
            end
            if (acc) pend--;
            if (tick && pend < PMAX) pend++;
            launch = 0;
            if (q.size() == 0) begin
                if (ph == 0) begin
                    pw++;
                    if (pw == PWRUP) begin launch = 1; ph = 1; end
                end else if (ph == 1) begin
                    if (init_left > 0) launch = 1;
                    else begin ph = 2; e_ready = 1; end
                end else if (acc) launch = 1;
            end
            if (launch) begin
                push_seq(cbr);
                if (ph == 1) init_left--;
            end
            if (q.size() > 0) begin e = q.pop_front(); e_busy = 1; end
            else begin e = '{1'b1, 1'b1, 1'b0, '0}; e_busy = 0; end
            e_req = e_ready && !e_busy && (pend > 0);
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic finish_run;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (WD_CYC) @(posedge clk);
        checks++; fails++;
        $display("FAIL R2 watchdog: actual run still going expected finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk); #1;
        // R1: reset / power-up state
        chk("R1", {ras_n, cas_lo_n, cas_hi_n, ready, req}, 5'b11100);
        while (!ready) @(posedge clk);
        #1;
        // R2: warm-up refresh count before ready
        chk("R2", init_falls, INIT);
        // R8: grant always available, strobe-first
        tag = "R8"; grant = 1'b1;
        wait_cyc(100);
        // R7: first request exactly one interval after ready
        chk("R7", req_cyc - rdy_cyc, RI);
        // R10: mode changes between refreshes
        tag = "R10";
        for (int k = 0; k < 20; k++) begin
            cbr = ~cbr;
            wait_cyc(7);
        end
        // R9: backlog saturates while arbiter withholds grant
        tag = "R9"; grant = 1'b0; cbr = 1'b1;
        wait_cyc(RI * (PMAX + 3));
        grant = 1'b1;
        wait_cyc(150);
        // R6: long row-address run to force the counter to wrap
        tag = "R6"; cbr = 1'b0;
        wait_cyc(520 * RI);
        chk("R6", wrap_ok, 1);
        finish_run();
    end
endmodule